// File: doc/BRIEF.md
# I2C Controller Event Status and Stall Unit

This unit collects the single-cycle event pulses raised by an I2C controller's transfer engine. Each pulse is latched into a sticky status bit. An enable mask chosen by software decides which latched bits drive the interrupt line. Software removes bits by writing ones to a clear port. Zeros written there have no effect.

The unit also drives a stall output to the transfer engine. The stall is high while any status bit is latched, whether or not that bit is enabled. The engine therefore waits at every event. The software write that clears the last pending bit is what lets the engine take its next step.

One ordering rule is enforced at the input. When the RX-FIFO-full pulse and the RX-byte-count-reached pulse arrive in the same cycle, the count bit is latched one cycle after the full bit. This way the FIFO-full bit is always seen first. The case comes up when the receive length is a whole multiple of the FIFO depth.

Top module: `i2cint_unit`

## Requirements
- R1: While `rst` is high, and after it is released, `status_o` and `enable_o` read zero and both `irq_o` and `stall_o` are low.
- R2: A pulse on `evt_i[k]` for an implemented bit k sets `status_o[k]` at the next rising edge. The bit stays set until it is cleared. The implemented bits and their events are:
  - 9: TX FIFO empty
  - 8: RX FIFO full
  - 7: send complete with STOP
  - 6: receive complete with STOP
  - 5: TX byte count reached
  - 4: RX byte count reached
  - 2: no acknowledge
  - 1: arbitration lost
- R3: A write with `wr_en_i`=1 and `wr_sel_i`=1 clears each status bit where `wr_data_i` holds a one, at that edge. Status bits where `wr_data_i` holds zero are unchanged.
- R4: An event pulse in the same cycle as a clear of the same bit leaves that bit set.
- R5: A write with `wr_en_i`=1 and `wr_sel_i`=0 loads `enable_o` from `wr_data_i`. `irq_o` equals the OR over all bits of `status_o` AND `enable_o`, and it updates at the same edge as those registers.
- R6: `stall_o` is high exactly when any `status_o` bit is set, regardless of `enable_o`.
- R7: Bits 0 and 3 are not implemented. Pulses on them never set status, and they always read zero in `enable_o`.
- R8: If `evt_i[8]` and `evt_i[4]` pulse in the same cycle, bit 8 is set at that edge and bit 4 is set at the following edge.
- R9: An enable write does not change `status_o`, and a clear write does not change `enable_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | STAT_W | Single-cycle event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the enable register, 1 selects the clear port |
| wr_data_i | input | STAT_W | Write data |
| status_o | output | STAT_W | Latched event status |
| enable_o | output | STAT_W | Interrupt enable mask |
| irq_o | output | 1 | Interrupt request (registered) |
| stall_o | output | 1 | Pause request to the transfer engine (registered) |

## Verification
The assertions assume that every event pulse lasts one cycle and that the write strobe qualifies the select and data inputs in the same cycle. They also assume that the event sources never repeat the RX-full and RX-count pair on back-to-back cycles. The ordering check relies on that spacing. The stimulus drives one step per cycle, with every pulse dropped at the next step. After each deferred RX pair it leaves at least one cycle with no events. The set-wins collisions and the clearing of the deferred bit are driven on purpose, inside those limits.

// File: rtl/i2cint_pkg.sv
package i2cint_pkg;
  localparam int STAT_W_DEF = 10;
  localparam int BIT_TXEMPTY = 9;
  localparam int BIT_RXFULL  = 8;
  localparam int BIT_TXSTOP  = 7;
  localparam int BIT_RXSTOP  = 6;
  localparam int BIT_TXCNT   = 5;
  localparam int BIT_RXCNT   = 4;
  localparam int BIT_NOACK   = 2;
  localparam int BIT_ARBLOST = 1;

  function automatic logic [STAT_W_DEF-1:0] impl_mask();
    logic [STAT_W_DEF-1:0] m;
    m = '0;
    m[BIT_TXEMPTY] = 1'b1;
    m[BIT_RXFULL]  = 1'b1;
    m[BIT_TXSTOP]  = 1'b1;
    m[BIT_RXSTOP]  = 1'b1;
    m[BIT_TXCNT]   = 1'b1;
    m[BIT_RXCNT]   = 1'b1;
    m[BIT_NOACK]   = 1'b1;
    m[BIT_ARBLOST] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/i2cint_order.sv
module i2cint_order #(
  parameter int STAT_W = i2cint_pkg::STAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  output logic [STAT_W-1:0] set_o
);
  localparam logic [STAT_W-1:0] IMPL = i2cint_pkg::impl_mask();
  localparam int RF = i2cint_pkg::BIT_RXFULL;
  localparam int RB = i2cint_pkg::BIT_RXCNT;

  logic [STAT_W-1:0] evt_m;
  logic              clash;
  logic              hold_q;

  assign evt_m = evt_i & IMPL;
  assign clash = evt_m[RF] & evt_m[RB];

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= clash;
  end

  always_comb begin
    set_o = evt_m;
    if (clash) set_o[RB] = 1'b0;
    if (hold_q) set_o[RB] = 1'b1;
  end
endmodule

// File: rtl/i2cint_status.sv
module i2cint_status #(
  parameter int STAT_W = i2cint_pkg::STAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_d,
  output logic [STAT_W-1:0] stat_q
);
  for (genvar k = 0; k < STAT_W; k++) begin : g_cell
    assign stat_d[k] = set_i[k] | (stat_q[k] & ~clr_i[k]);
    always_ff @(posedge clk) begin
      if (rst) stat_q[k] <= 1'b0;
      else     stat_q[k] <= stat_d[k];
    end
  end
endmodule

// File: rtl/i2cint_mask.sv
module i2cint_mask #(
  parameter int STAT_W = i2cint_pkg::STAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [STAT_W-1:0] data_i,
  output logic [STAT_W-1:0] en_d,
  output logic [STAT_W-1:0] en_q
);
  localparam logic [STAT_W-1:0] IMPL = i2cint_pkg::impl_mask();

  assign en_d = we_i ? (data_i & IMPL) : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/i2cint_unit.sv
module i2cint_unit #(
  parameter int STAT_W = i2cint_pkg::STAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic              irq_o,
  output logic              stall_o
);
  logic [STAT_W-1:0] set_w;
  logic [STAT_W-1:0] clr_w;
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] en_d;
  logic              irq_q;
  logic              stall_q;

  assign clr_w = (wr_en_i && wr_sel_i) ? wr_data_i : '0;

  i2cint_order #(.STAT_W(STAT_W)) u_order (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_i),
    .set_o (set_w)
  );

  i2cint_status #(.STAT_W(STAT_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_w),
    .clr_i  (clr_w),
    .stat_d (stat_d),
    .stat_q (status_o)
  );

  i2cint_mask #(.STAT_W(STAT_W)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we_i   (wr_en_i && !wr_sel_i),
    .data_i (wr_data_i),
    .en_d   (en_d),
    .en_q   (enable_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      irq_q   <= |(stat_d & en_d);
      stall_q <= |stat_d;
    end
  end

  assign irq_o   = irq_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/i2cint_chk.sv
module i2cint_chk #(
  parameter int STAT_W = i2cint_pkg::STAT_W_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic [STAT_W-1:0] evt_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [STAT_W-1:0] wr_data_i,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] enable_o,
  input logic              irq_o,
  input logic              stall_o
);
  localparam logic [STAT_W-1:0] IMPL = i2cint_pkg::impl_mask();
  localparam int RF = i2cint_pkg::BIT_RXFULL;
  localparam int RB = i2cint_pkg::BIT_RXCNT;

  logic [STAT_W-1:0] direct_set;
  logic [STAT_W-1:0] clr_now;
  logic              pair_now;

  assign pair_now = evt_i[RF] && evt_i[RB];
  always_comb begin
    direct_set = evt_i & IMPL;
    if (pair_now) direct_set[RB] = 1'b0;
  end
  assign clr_now = (wr_en_i && wr_sel_i) ? wr_data_i : '0;

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & $past(direct_set)) == $past(direct_set)));

  p_clear_only_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_o) & ~status_o & ~$past(clr_now)) == '0));

  p_irq_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_o & enable_o));

  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    stall_o == (status_o != '0));

  p_unimpl_r7: assert property (@(posedge clk) disable iff (rst)
    ((status_o | enable_o) & ~IMPL) == '0);

  p_order_r8: assert property (@(posedge clk) disable iff (rst)
    pair_now |=> (status_o[RF] ##1 status_o[RB]));

  p_enable_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && !wr_sel_i) |=> $stable(enable_o));
endmodule

bind i2cint_unit i2cint_chk #(.STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .status_o  (status_o),
  .enable_o  (enable_o),
  .irq_o     (irq_o),
  .stall_o   (stall_o)
);

// File: tb/sim_i2cint_unit.sv
`timescale 1ns/1ps
module sim_i2cint_unit;
  localparam int W = 10;
  localparam logic [W-1:0] IMPL = 10'h3F6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] evt = '0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] status_o, enable_o;
  logic         irq_o, stall_o;

  always #2.5 clk = ~clk;

  i2cint_unit #(.STAT_W(W)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .status_o(status_o), .enable_o(enable_o),
    .irq_o(irq_o), .stall_o(stall_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] st;
    logic [W-1:0] en;
    logic         irq;
    logic         stall;
    string        tag;
  } exp_t;
  exp_t q[$];

  logic [W-1:0] m_st = '0, m_en = '0;
  logic         m_hold = 1'b0;

  task automatic compare(exp_t e);
    checks++;
    if (status_o !== e.st || enable_o !== e.en || irq_o !== e.irq || stall_o !== e.stall) begin
      errors++;
      $display("FAIL %s: got st=%h en=%h irq=%b stall=%b exp st=%h en=%h irq=%b stall=%b",
               e.tag, status_o, enable_o, irq_o, stall_o, e.st, e.en, e.irq, e.stall);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(input logic [W-1:0] ev, input logic we, input logic sel,
                      input logic [W-1:0] dat, input string tag);
    logic [W-1:0] set, clr;
    exp_t e;
    @(negedge clk);
    evt = ev; wr_en = we; wr_sel = sel; wr_data = dat;
    set = ev & IMPL;
    if (set[8] && set[4]) begin set[4] = 1'b0; end
    if (m_hold) set[4] = 1'b1;
    m_hold = ev[8] && ev[4];
    clr = (we && sel) ? dat : '0;
    m_st = (m_st & ~clr) | set;
    if (we && !sel) m_en = dat & IMPL;
    e.st = m_st; e.en = m_en; e.irq = |(m_st & m_en); e.stall = |m_st; e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (status_o !== '0 || enable_o !== '0 || irq_o !== 1'b0 || stall_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got st=%h en=%h irq=%b stall=%b exp all zero",
               status_o, enable_o, irq_o, stall_o);
    end
    rst = 1'b0;
    step('0, 0, 0, '0, "R1 idle after reset");
    step(10'h200, 0, 0, '0, "R2 tx-empty sets bit 9, R6 stall");
    step('0, 0, 0, '0, "R2 bit 9 sticky");
    step(10'h009, 0, 0, '0, "R7 events on bits 0 and 3 ignored");
    step('0, 1, 0, 10'h3FF, "R7 enable unimplemented bits read zero, R5 irq");
    step('0, 1, 0, 10'h000, "R9 enable write keeps status, R5 irq low, R6 stall");
    step('0, 1, 0, 10'h200, "R5 enable bit 9 raises irq");
    step('0, 1, 1, 10'h200, "R3 clear bit 9, R6 stall drops");
    step(10'h0C6, 0, 0, '0, "R2 set bits 7 6 2 1");
    step('0, 1, 1, 10'h044, "R3 partial clear, R9 enable kept");
    step(10'h080, 1, 1, 10'h080, "R4 set wins over clear on bit 7");
    step('0, 1, 1, 10'h3FF, "R3 clear all");
    step(10'h110, 0, 0, '0, "R8 rx-full first");
    step('0, 0, 0, '0, "R8 rx-count one cycle later");
    step('0, 1, 1, 10'h3FF, "R3 clear after pair");
    step(10'h110, 0, 0, '0, "R8 second pair");
    step('0, 1, 1, 10'h010, "R8 R4 deferred set wins over clear");
    step('0, 1, 0, 10'h010, "R5 enable rx-count irq");
    step(10'h010, 0, 0, '0, "R2 lone rx-count sets directly");
    step('0, 1, 1, 10'h3FF, "R3 final clear");
    step('0, 0, 0, '0, "R6 idle no stall");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule